// File: doc/BRIEF.md
# Start/Stop Framing Serializer

This block turns a stream of 18-bit parallel words into a serial bit stream. A reference-clock strobe marks each new parallel word. Every word is wrapped in a start bit and a stop bit to form a 20-bit frame, and the frame is shifted out one bit per fast-clock cycle. A reference-clock period therefore spans exactly 20 serial slots. The serial side is modelled as one bit per cycle on a single fast clock. The strobe is a one-cycle pulse in that clock domain.

A sync input replaces the payload with a fixed alignment pattern, so that a receiver can find frame boundaries at once during link bring-up. A loopback input sends the serial stream to an internal loopback output and parks the external line in its inactive state. An enable input powers the block down. When enable rises, the block waits a programmable number of reference ticks before the first frame goes out. The line stays inactive for that whole wait.

Top module: `frame_serializer`

## Requirements
- R1: Each frame occupies 20 consecutive serial slots. Slot 0 carries the start bit, value 1. Slots 1 to 18 carry payload bits 0 to 17, least significant bit first. Slot 19 carries the stop bit, value 0.
- R2: When a reference tick coincides with a frame boundary, the word presented with that tick is the payload of the frame that starts next.
- R3: A word whose tick falls in the middle of a frame does not disturb the frame in progress. It becomes the payload of the following frame.
- R4: If no tick has arrived since the last frame was loaded, the next frame repeats the most recently received word.
- R5: The sync input is sampled at the frame boundary. When it is high, the payload becomes the constant 18'b111111111000000000 (bits 17..9 are 1, bits 8..0 are 0), so slots 1-9 send 0 and slots 10-18 send 1.
- R6: While loopback is high, the frame bits appear on loopOut, serOut stays 0 and serHiZ is 1. While loopback is low, loopOut stays 0.
- R7: One cycle after enable goes low, serOut and loopOut are 0 and serHiZ is 1, even in the middle of a frame. This holds until enable returns.
- R8: After enable rises, serOut stays 0 and serHiZ stays 1 through RST_TICKS reference ticks. The tick that completes the count loads the first frame, and its start bit appears in the next cycle.
- R9: While rstN is low, serOut and loopOut are 0 and serHiZ is 1.
- R10: While the block is transmitting, frames follow back to back. A new frame is loaded exactly once every 20 slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast serial-bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | High for operation, low for power-down |
| refTick | input | 1 | One-cycle strobe marking a reference-clock rising edge |
| dataIn | input | 18 | Parallel word captured on refTick |
| syncMode | input | 1 | Replace payload with the alignment pattern |
| loopEn | input | 1 | Route the serial stream to loopOut |
| serOut | output | 1 | External serial line |
| serHiZ | output | 1 | High when the external line is inactive (high impedance) |
| loopOut | output | 1 | Internal loopback serial stream |

## Verification
The bench builds the block with an 18-bit payload and RST_TICKS set to 3. A three-tick wake-up is short enough to repeat after each power-down and each reset. It is still long enough to prove that neither the first nor the middle tick releases the line early. During wake-up the ticks are spaced a few cycles apart. Once frames flow, they are aligned to 20-slot boundaries. This lets the bench place one tick mid-frame and deliberately leave one boundary without a tick. Those placements exercise the hold and repeat paths.

// File: rtl/frame_ser_pkg.sv
package frame_ser_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WARM = 2'd1,
    ST_RUN  = 2'd2
  } ser_state_e;

  // Strobes the control hands to the datapath each cycle.
  typedef struct packed {
    logic load;     // build a fresh frame into the shifter
    logic shift;    // advance the shifter by one slot
    logic running;  // line is live: frames are being sent
  } ser_strobe_t;

endpackage

// File: rtl/frame_ser_ctrl.sv
module frame_ser_ctrl
  import frame_ser_pkg::*;
#(
  parameter int FRAME_W   = 20,
  parameter int RST_TICKS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        refTick,
  output ser_strobe_t strobes
);

  localparam int BIT_W  = $clog2(FRAME_W);
  localparam int TICK_W = (RST_TICKS > 1) ? $clog2(RST_TICKS) : 1;
  localparam logic [BIT_W-1:0]  LAST_SLOT = BIT_W'(FRAME_W - 1);
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(RST_TICKS - 1);

  ser_state_e       state;
  logic [BIT_W-1:0] bitCnt;
  logic [TICK_W-1:0] tickCnt;

  logic lastSlot;
  logic lastTick;
  logic warmDone;
  logic frameWrap;

  assign lastSlot  = (bitCnt == LAST_SLOT);
  assign lastTick  = (tickCnt == LAST_TICK);
  assign warmDone  = (state == ST_WARM) && refTick && lastTick;
  assign frameWrap = (state == ST_RUN) && lastSlot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_OFF;
      bitCnt  <= '0;
      tickCnt <= '0;
    end else if (!enable) begin
      state   <= ST_OFF;
      bitCnt  <= '0;
      tickCnt <= '0;
    end else begin
      unique case (state)
        ST_OFF: begin
          state   <= ST_WARM;
          tickCnt <= '0;
        end
        ST_WARM: begin
          if (refTick) begin
            if (lastTick) begin
              state  <= ST_RUN;
              bitCnt <= '0;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        ST_RUN: begin
          bitCnt <= lastSlot ? '0 : bitCnt + 1'b1;
        end
        default: state <= ST_OFF;
      endcase
    end
  end

  always_comb begin
    strobes.load    = enable && (warmDone || frameWrap);
    strobes.shift   = enable && (state == ST_RUN) && !frameWrap;
    strobes.running = (state == ST_RUN);
  end

endmodule

// File: rtl/frame_ser_datapath.sv
module frame_ser_datapath
  import frame_ser_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              syncMode,
  input  logic              loopEn,
  input  ser_strobe_t       strobes,
  output logic              serOut,
  output logic              serHiZ,
  output logic              loopOut
);

  localparam int FRAME_W = DATA_W + 2;
  localparam int HALF_W  = DATA_W / 2;

  logic [DATA_W-1:0]  syncPattern;
  logic [DATA_W-1:0]  holdWord;
  logic [DATA_W-1:0]  freshWord;
  logic [DATA_W-1:0]  payload;
  logic [FRAME_W-1:0] shifter;
  logic               lineBit;

  // Alignment pattern: upper half ones, lower half zeros.
  for (genvar i = 0; i < DATA_W; i++) begin : g_sync
    assign syncPattern[i] = (i >= HALF_W);
  end

  // Latest word from the reference side; overwritten by each tick.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdWord <= '0;
    else if (refTick) holdWord <= dataIn;
  end

  // A tick landing on the boundary feeds its word straight in.
  assign freshWord = refTick ? dataIn : holdWord;
  assign payload   = syncMode ? syncPattern : freshWord;

  // Frame shifter, sent LSB first: start(1), payload, stop(0).
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shifter <= '0;
    end else if (strobes.load) begin
      shifter <= {1'b0, payload, 1'b1};
    end else if (strobes.shift) begin
      shifter <= {1'b0, shifter[FRAME_W-1:1]};
    end
  end

  assign lineBit = strobes.running && shifter[0];
  assign serOut  = lineBit && !loopEn;
  assign loopOut = lineBit && loopEn;
  assign serHiZ  = !strobes.running || loopEn;

endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
  import frame_ser_pkg::*;
#(
  parameter int DATA_W    = 18,
  parameter int RST_TICKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              refTick,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              syncMode,
  input  logic              loopEn,
  output logic              serOut,
  output logic              serHiZ,
  output logic              loopOut
);

  localparam int FRAME_W = DATA_W + 2;

  ser_strobe_t ctrlStrobe;

  frame_ser_ctrl #(
    .FRAME_W  (FRAME_W),
    .RST_TICKS(RST_TICKS)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .refTick(refTick),
    .strobes(ctrlStrobe)
  );

  frame_ser_datapath #(
    .DATA_W(DATA_W)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .refTick (refTick),
    .dataIn  (dataIn),
    .syncMode(syncMode),
    .loopEn  (loopEn),
    .strobes (ctrlStrobe),
    .serOut  (serOut),
    .serHiZ  (serHiZ),
    .loopOut (loopOut)
  );

endmodule

// File: rtl/frame_ser_checker.sv
module frame_ser_checker
  import frame_ser_pkg::*;
#(
  parameter int FRAME_W = 20
) (
  input logic        clk,
  input logic        rstN,
  input logic        enable,
  input logic        loopEn,
  input logic        serOut,
  input logic        serHiZ,
  input logic        loopOut,
  input ser_strobe_t strobes
);

  localparam int SLOT_W = $clog2(FRAME_W) + 1;
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME_W - 1);

  logic [SLOT_W-1:0] slot;
  logic              anyBit;

  assign anyBit = serOut || loopOut;

  // Independent slot count since the last frame load (saturating).
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) slot <= '1;
    else if (strobes.load) slot <= '0;
    else if (slot != '1) slot <= slot + 1'b1;
  end

  p_start_bit_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.running && slot == '0) |-> anyBit)
    else $error("start bit missing");

  p_stop_bit_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.running && slot == LAST) |-> !anyBit)
    else $error("stop bit not zero");

  p_frame_spacing_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && strobes.running) |-> (slot == LAST))
    else $error("frame loaded off boundary");

  p_loop_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    loopEn |-> (serHiZ && !serOut))
    else $error("external line active in loopback");

  p_powerdown_r7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (serHiZ && !serOut && !loopOut))
    else $error("line active after power-down");

  p_idle_line_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.running |-> (serHiZ && !serOut && !loopOut))
    else $error("line active before transmit");

endmodule

bind frame_serializer frame_ser_checker #(.FRAME_W(FRAME_W)) u_checker (
  .clk    (clk),
  .rstN   (rstN),
  .enable (enable),
  .loopEn (loopEn),
  .serOut (serOut),
  .serHiZ (serHiZ),
  .loopOut(loopOut),
  .strobes(ctrlStrobe)
);

// File: tb/frame_serializer_bench.sv
`timescale 1ns/1ps
module frame_serializer_bench;

  localparam int DW = 18;
  localparam int RT = 3;
  localparam logic [DW-1:0] SYNC_WORD = 18'b111111111000000000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          enable = 1'b0;
  logic          refTick = 1'b0;
  logic [DW-1:0] dataIn = '0;
  logic          syncMode = 1'b0;
  logic          loopEn = 1'b0;
  logic          serOut, serHiZ, loopOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  frame_serializer #(.DATA_W(DW), .RST_TICKS(RT)) u_frame_serializer (
    .clk(clk), .rstN(rstN), .enable(enable), .refTick(refTick),
    .dataIn(dataIn), .syncMode(syncMode), .loopEn(loopEn),
    .serOut(serOut), .serHiZ(serHiZ), .loopOut(loopOut)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkIdle(input string req);
    check(req, "idle line", {29'd0, serOut, serHiZ, loopOut}, 32'b010);
  endtask

  // Enable and walk the wake-up: RT ticks, the last one loads `word`.
  task automatic warmUp(input logic [DW-1:0] word);
    enable = 1'b1;
    for (int t = 0; t < RT; t++) begin
      repeat (3) begin
        @(negedge clk);
        checkIdle("R8");
      end
      refTick = 1'b1;
      dataIn  = word;
      @(negedge clk);
      refTick = 1'b0;
      if (t < RT - 1) checkIdle("R8");
    end
  endtask

  // Advance across a frame boundary, optionally presenting a tick.
  task automatic boundary(input bit tick, input logic [DW-1:0] word, input bit sync);
    syncMode = sync;
    if (tick) begin
      refTick = 1'b1;
      dataIn  = word;
    end
    @(negedge clk);
    refTick  = 1'b0;
    syncMode = 1'b0;
  endtask

  // Sample the 20 slots of the frame just loaded.
  task automatic frame(input logic [DW-1:0] word, input bit loop,
                       input int midAt, input logic [DW-1:0] midWord, input string tag);
    for (int k = 0; k < DW + 2; k++) begin
      logic expBit;
      string req;
      if (k == 0) begin expBit = 1'b1; req = "R1"; end
      else if (k == DW + 1) begin expBit = 1'b0; req = "R1"; end
      else begin expBit = word[k-1]; req = tag; end
      if (loop) begin
        check(req, $sformatf("loop slot %0d", k), {31'd0, loopOut}, {31'd0, expBit});
        check("R6", "ext quiet in loop", {30'd0, serOut, serHiZ}, 32'b01);
      end else begin
        check(req, $sformatf("slot %0d", k), {31'd0, serOut}, {31'd0, expBit});
        check("R6", "loop quiet", {30'd0, loopOut, serHiZ}, 32'b00);
      end
      if (k == midAt) begin
        refTick = 1'b1;
        dataIn  = midWord;
      end
      if (k < DW + 1) begin
        @(negedge clk);
        refTick = 1'b0;
      end
    end
  endtask

  task automatic test_reset_state();
    repeat (3) @(negedge clk);
    checkIdle("R9");
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R9");
  endtask

  task automatic test_basic();
    warmUp(18'h2A5C3);
    frame(18'h2A5C3, 0, -1, '0, "R2");
    boundary(1, 18'h15A3C, 0);
    frame(18'h15A3C, 0, -1, '0, "R2");
    boundary(1, 18'h3FFFF, 0);
    frame(18'h3FFFF, 0, -1, '0, "R10");
    boundary(1, 18'h00000, 0);
    frame(18'h00000, 0, -1, '0, "R10");
  endtask

  task automatic test_hold();
    boundary(1, 18'h0F0F0, 0);
    frame(18'h0F0F0, 0, 7, 18'h31234, "R2");
    boundary(0, '0, 0);
    frame(18'h31234, 0, -1, '0, "R3");
    boundary(0, '0, 0);
    frame(18'h31234, 0, -1, '0, "R4");
  endtask

  task automatic test_sync();
    boundary(1, 18'h12345, 1);
    frame(SYNC_WORD, 0, -1, '0, "R5");
    boundary(1, 18'h2BCDE, 0);
    frame(18'h2BCDE, 0, -1, '0, "R5");
  endtask

  task automatic test_loop();
    loopEn = 1'b1;
    boundary(1, 18'h1C3E7, 0);
    frame(18'h1C3E7, 1, -1, '0, "R6");
    loopEn = 1'b0;
    boundary(1, 18'h0A0A5, 0);
    frame(18'h0A0A5, 0, -1, '0, "R6");
  endtask

  task automatic test_powerdown();
    boundary(1, 18'h3C3C3, 0);
    repeat (6) @(negedge clk);
    enable = 1'b0;
    repeat (4) begin
      @(negedge clk);
      checkIdle("R7");
    end
    warmUp(18'h24681);
    frame(18'h24681, 0, -1, '0, "R8");
  endtask

  task automatic test_async_reset();
    boundary(1, 18'h1357A, 0);
    repeat (4) @(negedge clk);
    rstN = 1'b0;
    #1;
    checkIdle("R9");
    @(negedge clk);
    checkIdle("R9");
    rstN = 1'b1;
    warmUp(18'h0BEEF);
    frame(18'h0BEEF, 0, -1, '0, "R9");
  endtask

  initial begin
    test_reset_state();
    test_basic();
    test_hold();
    test_sync();
    test_loop();
    test_powerdown();
    test_async_reset();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule